// File: doc/BRIEF.md
# Pause-width modulated frame transmitter

This block sends a short command frame from a reader to a tag by switching a single carrier-enable line. Each data bit takes one bit cell, and the bit value is carried only by how long the cell lasts. Every cell opens with a carrier-off gap of fixed length. The carrier then comes back on until the cell ends: a long cell stands for a one and a short cell for a zero. When the last cell is done, one more carrier-off gap closes the frame and the carrier is switched back on.

All timing is counted in ticks of a shared timebase. The tick enable comes in from a clock divider outside the block, which divides the system clock by 32 by default. A one-cycle done pulse marks the moment the closing gap ends. The surrounding logic uses that pulse to restart the shared tick counter, so that the receive window for the tag's reply is measured from the end of the frame. The caller supplies a data word of up to `MAX_BITS` bits and a bit count, then strobes start. The bits leave least-significant first.

Top module: `pwtx_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, carrier_en is 1, busy is 0 and done is 0.
- R2: A start strobe taken while idle raises busy and drives carrier_en to 0 in the next cycle. A frame with bit count N shows N+1 carrier-off gaps in total.
- R3: Every bit cell begins with a carrier-off gap lasting exactly PAUSE_TICKS ticks.
- R4: A data bit of value 1 takes a cell of ONE_TICKS ticks in total, so the carrier stays on for ONE_TICKS-PAUSE_TICKS ticks after the gap.
- R5: A data bit of value 0 takes a cell of ZERO_TICKS ticks in total, so the carrier stays on for ZERO_TICKS-PAUSE_TICKS ticks after the gap.
- R6: Bit 0 of the data word is sent first, then bit 1, and so on up to bit N-1.
- R7: After the last cell, one closing carrier-off gap of PAUSE_TICKS ticks is sent, and then carrier_en returns to 1.
- R8: done is high for exactly one cycle: the first cycle after the closing gap. In that cycle busy is already 0 and carrier_en is 1. This pulse is the reference for restarting the shared timebase.
- R9: A start strobe that arrives while busy is ignored. The frame in progress goes on with its original data and bit count.
- R10: A bit count of 0 sends only the closing gap and then pulses done.
- R11: A bit count above MAX_BITS is treated as MAX_BITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Timebase tick enable, high for one clock per tick |
| start | input | 1 | Frame start strobe |
| data | input | MAX_BITS | Frame bits, least-significant sent first |
| nbits | input | NB_W | Number of bits to send |
| carrier_en | output | 1 | Carrier enable: 0 during gaps, 1 otherwise |
| busy | output | 1 | High while a frame is in progress |
| done | output | 1 | One-cycle pulse when the frame ends |

## Verification
The bench shrinks the timing to a 2-tick gap, a 4-tick zero cell and a 7-tick one cell, and ticks once every three clocks. With MAX_BITS left at 16, every bit count from 0 to 20 can be swept against several data patterns and a walking one, and a full frame still lasts only a few hundred cycles. The bench measures each carrier-off and carrier-on stretch in ticks and decodes the bits from those lengths. Because of that, the clamp, the empty frame and the ignored restart strobe are all checked through the carrier line and the done pulse.

// File: rtl/pwtx_pkg.sv
package pwtx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_GAP   = 2'd1,
      ST_MARK  = 2'd2,
      ST_CLOSE = 2'd3
   } pwtx_state_e;

endpackage

// File: rtl/pwtx_cell_timer.sv
module pwtx_cell_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          tick,
   output logic [CW-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/pwtx_bit_shifter.sv
module pwtx_bit_shifter #(
   parameter int W  = 16,
   parameter int BW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          shift,
   input  logic [W-1:0]  din,
   input  logic [BW-1:0] count,
   output logic          cur_bit,
   output logic          last,
   output logic [BW-1:0] left
);

   logic [W-1:0] sreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg <= '0;
         left <= '0;
      end else if (load) begin
         sreg <= din;
         left <= count;
      end else if (shift) begin
         sreg <= sreg >> 1;
         left <= left - 1'b1;
      end
   end

   assign cur_bit = sreg[0];
   assign last    = (left == BW'(1));

   AST_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      left <= BW'(W)); // R11

endmodule

// File: rtl/pwtx_frame_tx.sv
module pwtx_frame_tx
   import pwtx_pkg::*;
#(
   parameter int MAX_BITS    = 16,
   parameter int NB_W        = 5,
   parameter int PAUSE_TICKS = 30,
   parameter int ZERO_TICKS  = 90,
   parameter int ONE_TICKS   = 150
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_en,
   input  logic                start,
   input  logic [MAX_BITS-1:0] data,
   input  logic [NB_W-1:0]     nbits,
   output logic                carrier_en,
   output logic                busy,
   output logic                done
);

   localparam int BW = $clog2(MAX_BITS + 1);
   localparam int CW = $clog2(ONE_TICKS + 1);

   generate
      if (PAUSE_TICKS < 1 || ZERO_TICKS <= PAUSE_TICKS || ONE_TICKS <= ZERO_TICKS) begin : g_bad_timing
         $error("pwtx_frame_tx: need 0 < PAUSE_TICKS < ZERO_TICKS < ONE_TICKS");
      end
      if (NB_W < BW) begin : g_bad_count_width
         $error("pwtx_frame_tx: NB_W too narrow for MAX_BITS");
      end
   endgenerate

   pwtx_state_e   st, st_nx;
   logic [CW-1:0] cnt;
   logic          tmr_clr, sh_load, sh_shift, done_nx;
   logic          cur_bit, last_bit;
   logic [BW-1:0] left, nb_eff;
   logic [CW-1:0] cell_end;
   logic          gap_hit, cell_hit;

   assign nb_eff   = (nbits > NB_W'(MAX_BITS)) ? BW'(MAX_BITS) : BW'(nbits);
   assign cell_end = cur_bit ? CW'(ONE_TICKS - 1) : CW'(ZERO_TICKS - 1);
   assign gap_hit  = tick_en && (cnt == CW'(PAUSE_TICKS - 1));
   assign cell_hit = tick_en && (cnt == cell_end);

   pwtx_cell_timer #(.CW(CW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .tick  (tick_en),
      .cnt   (cnt)
   );

   pwtx_bit_shifter #(.W(MAX_BITS), .BW(BW)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (sh_load),
      .shift   (sh_shift),
      .din     (data),
      .count   (nb_eff),
      .cur_bit (cur_bit),
      .last    (last_bit),
      .left    (left)
   );

   always_comb begin
      st_nx    = st;
      tmr_clr  = 1'b0;
      sh_load  = 1'b0;
      sh_shift = 1'b0;
      done_nx  = 1'b0;
      case (st)
         ST_IDLE: begin
            tmr_clr = 1'b1;
            if (start) begin
               sh_load = 1'b1;
               st_nx   = (nb_eff == '0) ? ST_CLOSE : ST_GAP;
            end
         end
         ST_GAP: begin
            if (gap_hit) st_nx = ST_MARK;
         end
         ST_MARK: begin
            if (cell_hit) begin
               tmr_clr  = 1'b1;
               sh_shift = 1'b1;
               st_nx    = last_bit ? ST_CLOSE : ST_GAP;
            end
         end
         ST_CLOSE: begin
            if (gap_hit) begin
               tmr_clr = 1'b1;
               done_nx = 1'b1;
               st_nx   = ST_IDLE;
            end
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         done <= 1'b0;
      end else begin
         st   <= st_nx;
         done <= done_nx;
      end
   end

   assign carrier_en = !((st == ST_GAP) || (st == ST_CLOSE));
   assign busy       = (st != ST_IDLE);

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (carrier_en && !busy && $past(st == ST_CLOSE))); // R8
   AST_GAP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(carrier_en) && busy) |-> ($past(tick_en) && $past(cnt) == CW'(PAUSE_TICKS - 1))); // R3
   AST_CLOSE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(carrier_en) && !busy) |-> (done && $past(cnt) == CW'(PAUSE_TICKS - 1))); // R7
   AST_CELL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(ONE_TICKS - 1)); // R4
   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !sh_shift) |=> $stable(left)); // R9
   AST_EMPTY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && nbits == '0) |=> (st == ST_CLOSE)); // R10

endmodule

// File: tb/pwtx_frame_tx_tb.sv
module pwtx_frame_tx_tb;

   localparam int MAXB  = 16;
   localparam int NBW   = 5;
   localparam int PAUSE = 2;
   localparam int ZERO  = 4;
   localparam int ONE   = 7;
   localparam int TDIV  = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            tick_en = 1'b0;
   logic            start = 1'b0;
   logic [MAXB-1:0] data = '0;
   logic [NBW-1:0]  nbits = '0;
   logic            carrier_en, busy, done;

   int vectors = 0;
   int miscompares = 0;
   int tdiv_cnt = 0;

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      tdiv_cnt <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
      tick_en  <= (tdiv_cnt == TDIV - 1);
   end

   pwtx_frame_tx #(
      .MAX_BITS(MAXB), .NB_W(NBW), .PAUSE_TICKS(PAUSE),
      .ZERO_TICKS(ZERO), .ONE_TICKS(ONE)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start),
      .data(data), .nbits(nbits), .carrier_en(carrier_en),
      .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_frame(input logic [15:0] d, input int n, input bit inject);
      int    exp_n     = (n > MAXB) ? MAXB : n;
      int    gaps      = 0;
      int    bits_got  = 0;
      int    low_ticks = 0;
      int    hi_ticks  = 0;
      bit    prev_low  = 1'b0;
      bit    in_high   = 1'b0;
      bit    finished  = 1'b0;
      int    cyc       = 0;
      logic [31:0] got = '0;
      logic [31:0] expw;
      string cnt_tag   = (n == 0) ? "R10" : ((n > MAXB) ? "R11" : "R2");
      expw = 32'(d) & ((32'd1 << exp_n) - 32'd1);

      @(negedge clk);
      start = 1'b1; data = d; nbits = NBW'(n);
      @(negedge clk);
      start = 1'b0;
      chk(busy && !carrier_en, "R2 frame start", {30'd0, busy, carrier_en}, 2);
      while (!finished && cyc < 5000) begin
         if (inject && cyc == 5) begin
            start = 1'b1; data = ~d; nbits = NBW'(MAXB);
         end
         if (inject && cyc == 6) begin
            start = 1'b0;
            chk(busy, "R9 start while busy", int'(busy), 1);
         end
         if (!carrier_en) begin
            if (!prev_low) begin
               low_ticks = 0;
               if (in_high) begin
                  int b;
                  int eb = (bits_got < 32) ? int'(expw[bits_got]) : 0;
                  if (hi_ticks == ONE - PAUSE) b = 1;
                  else if (hi_ticks == ZERO - PAUSE) b = 0;
                  else b = -1;
                  chk(b == eb, eb ? "R4 one-cell length" : "R5 zero-cell length",
                      hi_ticks, eb ? ONE - PAUSE : ZERO - PAUSE);
                  if (b == 1 && bits_got < 32) got[bits_got] = 1'b1;
                  bits_got++;
               end
            end
            low_ticks += int'(tick_en);
            prev_low = 1'b1;
         end else begin
            if (prev_low) begin
               gaps++;
               chk(low_ticks == PAUSE, done ? "R7 closing gap" : "R3 leading gap",
                   low_ticks, PAUSE);
               hi_ticks = 0;
               in_high  = 1'b1;
            end
            hi_ticks += int'(tick_en);
            prev_low = 1'b0;
         end
         if (done) begin
            finished = 1'b1;
            chk(!busy && carrier_en, "R8 done state", {30'd0, busy, carrier_en}, 1);
         end else begin
            @(negedge clk);
            cyc++;
         end
      end
      chk(finished, "watchdog frame end", cyc, 5000);
      chk(gaps == exp_n + 1, cnt_tag, gaps, exp_n + 1);
      chk(bits_got == exp_n, cnt_tag, bits_got, exp_n);
      chk(got == expw, "R6 decoded word", int'(got), int'(expw));
      @(negedge clk);
      chk(!done && !busy && carrier_en, "R8 single pulse / R1 idle",
          {29'd0, done, busy, carrier_en}, 1);
   endtask

   initial begin
      logic [15:0] pats [4];
      pats[0] = 16'hFFFF; pats[1] = 16'h0000; pats[2] = 16'hA5C3; pats[3] = 16'h3C96;
      repeat (3) @(negedge clk);
      chk(carrier_en && !busy && !done, "R1 reset state", {29'd0, carrier_en, busy, done}, 4);
      rst_n = 1'b1;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         chk(carrier_en && !busy && !done, "R1 idle hold", {29'd0, carrier_en, busy, done}, 4);
      end
      for (int n = 0; n <= 20; n++)
         for (int p = 0; p < 4; p++)
            run_frame(pats[p], n, 1'b0);
      for (int k = 0; k < 16; k++)
         run_frame(16'(1 << k), 16, 1'b0);
      run_frame(16'h0F0F, 8, 1'b1);
      run_frame(16'h1234, 3, 1'b1);
      run_frame(16'hFFFF, 12, 1'b1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule